// File: doc/BRIEF.md
# Pulse-Coded Level Link Codec

This block moves one logic level across a channel that can only carry short pulses. It has two halves. The transmit half watches the data input and turns each change into a single one-cycle pulse: a set pulse when the level goes up, a clear pulse when it goes down. If the input then stays still, it keeps sending refresh pulses that repeat the present level. The receive half is a set/clear latch that those pulses steer. A watchdog drops the output to a default level, and lowers a link-valid flag, when pulses stop arriving. Such a stall should only happen while the sending side is unpowered or held inactive.

Both halves sit in one top module. The transmit pulse pair leaves on two output pins. The receive pulse pair comes in on two input pins, so the pulse channel between them lies outside the block. The data input and output are plain levels sampled every cycle. There is no item flow and no back-pressure, so the pins carry no valid/ready handshake. All timing windows are parameters counted in clock cycles. The defaults are 100, 100 and 500 cycles, which suit a 100 MHz clock.

Top module: `isolink_codec`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rx_level` equals `DEFAULT_LVL` (default 1), `link_ok` is 0, and both transmit pulse pins are 0. The transmitter's tracked level starts at 0.
- R2: When `din` goes from 0 to 1, `tx_set` is high for exactly one cycle, in the cycle after the one in which `din` was first sampled high. `tx_clr` stays low in that cycle.
- R3: When `din` goes from 1 to 0, `tx_clr` is high for exactly one cycle, in the cycle after the one in which `din` was first sampled low. `tx_set` stays low in that cycle.
- R4: After a pulse that follows an edge (or after reset), if `din` does not change for `IDLE_CYC` cycles, a refresh pulse is sent. It goes on `tx_set` when the level is 1 and on `tx_clr` when it is 0. After that, one refresh pulse follows every `REFRESH_CYC` cycles for as long as `din` stays still.
- R5: An input edge restarts the idle window. The next refresh comes `IDLE_CYC` cycles after the edge pulse, and an edge that is due in the same cycle as a refresh replaces that refresh.
- R6: `tx_set` and `tx_clr` are never high in the same cycle.
- R7: A cycle with `rx_set`=1 and `rx_clr`=0 makes `rx_level` 1 from the next cycle on. A cycle with `rx_clr`=1 and `rx_set`=0 makes it 0 from the next cycle on.
- R8: A cycle with `rx_set` and `rx_clr` both high changes neither `rx_level` nor `link_ok`, and it does not restart the watchdog.
- R9: `link_ok` rises in the cycle after the first valid receive pulse, and again after the first valid pulse that follows a timeout.
- R10: If `TIMEOUT_CYC` cycles pass after the cycle of the last valid receive pulse with no new valid pulse, `rx_level` returns to `DEFAULT_LVL` and `link_ok` falls in the next cycle. Both then stay there until a valid pulse arrives.
- R11: With the transmit pins looped back to the receive pins and `TIMEOUT_CYC` greater than `REFRESH_CYC`, a steady input never lets the link time out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Data level to send |
| tx_set | output | 1 | Transmit pulse: level is 1 |
| tx_clr | output | 1 | Transmit pulse: level is 0 |
| rx_set | input | 1 | Received pulse: drive level to 1 |
| rx_clr | input | 1 | Received pulse: drive level to 0 |
| rx_level | output | 1 | Recovered data level |
| link_ok | output | 1 | High while pulses keep arriving in time |

## Verification
The assertions assume that `IDLE_CYC` and `REFRESH_CYC` are at least 2, so that two pulses of the same kind never touch. They also assume that a receive pair with both lines high appears only as an injected fault, never as a transmitted pulse. The stimulus meets these assumptions. It uses small windows (8, 6 and 20 cycles) and loops the transmit pins back to the receive pins. It departs from the loopback in only two ways: it raises both receive lines together for one cycle at the moment an edge pulse arrives, and it gates the channel off for longer than the timeout. Input changes occur at least one cycle apart, and the stimulus includes back-to-back opposite edges.

// File: rtl/isolink_pkg.sv
package isolink_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } pulse_pair_t;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/isolink_gap_timer.sv
module isolink_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = run && !restart && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || hit)   cnt <= '0;
    else if (run)              cnt <= cnt + 1'b1;
  end

  // R4 / R10: the count never passes the window it is timing
  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (cnt < limit));

endmodule

// File: rtl/isolink_tx.sv
module isolink_tx
  import isolink_pkg::*;
#(
  parameter int IDLE_CYC    = 100,
  parameter int REFRESH_CYC = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        din,
  output pulse_pair_t pls
);
  localparam int MAXG = (IDLE_CYC > REFRESH_CYC) ? IDLE_CYC : REFRESH_CYC;
  localparam int W    = cnt_width(MAXG + 1);

  logic         lvl_q;
  logic         first_q;
  logic         edge_w;
  logic         hit;
  logic [W-1:0] lim;

  assign edge_w = din ^ lvl_q;
  assign lim    = first_q ? W'(IDLE_CYC) : W'(REFRESH_CYC);

  isolink_gap_timer #(.W(W)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart(edge_w), .run(1'b1),
    .limit(lim), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      first_q <= 1'b1;
      pls     <= '0;
    end else begin
      lvl_q   <= din;
      pls.set <= (edge_w && din)  || (hit && lvl_q);
      pls.clr <= (edge_w && !din) || (hit && !lvl_q);
      if (edge_w)   first_q <= 1'b1;
      else if (hit) first_q <= 1'b0;
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pls.set && pls.clr));

  assert_set_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pls.set |=> !pls.set);

  assert_clr_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pls.clr |=> !pls.clr);

  // R2 / R3: an edge yields the matching pulse in the next cycle
  assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (pls.set == $past(din)) && (pls.clr == !$past(din)));

endmodule

// File: rtl/isolink_rx.sv
module isolink_rx
  import isolink_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500,
  parameter bit DEFAULT_LVL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pulse_pair_t pls,
  output logic        level,
  output logic        link_ok
);
  localparam int W = cnt_width(TIMEOUT_CYC + 1);

  logic valid_w;
  logic expire;

  assign valid_w = pls.set ^ pls.clr;

  isolink_gap_timer #(.W(W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .restart(valid_w), .run(link_ok),
    .limit(W'(TIMEOUT_CYC)), .hit(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= DEFAULT_LVL;
      link_ok <= 1'b0;
    end else if (valid_w) begin
      level   <= pls.set;
      link_ok <= 1'b1;
    end else if (expire) begin
      level   <= DEFAULT_LVL;
      link_ok <= 1'b0;
    end
  end

  assert_set_drives_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pls.set && !pls.clr) |=> level);

  assert_clr_drives_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pls.clr && !pls.set) |=> !level);

  assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pls.set && pls.clr && !expire) |=> ($stable(level) && $stable(link_ok)));

  assert_link_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_w |=> link_ok);

  assert_timeout_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> (level == DEFAULT_LVL));

endmodule

// File: rtl/isolink_codec.sv
module isolink_codec
  import isolink_pkg::*;
#(
  parameter int IDLE_CYC    = 100,
  parameter int REFRESH_CYC = 100,
  parameter int TIMEOUT_CYC = 500,
  parameter bit DEFAULT_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic rx_level,
  output logic link_ok
);
  pulse_pair_t tx_p;
  pulse_pair_t rx_p;

  assign tx_set = tx_p.set;
  assign tx_clr = tx_p.clr;
  assign rx_p   = '{set: rx_set, clr: rx_clr};

  isolink_tx #(.IDLE_CYC(IDLE_CYC), .REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .din(din), .pls(tx_p)
  );

  isolink_rx #(.TIMEOUT_CYC(TIMEOUT_CYC), .DEFAULT_LVL(DEFAULT_LVL)) u_rx (
    .clk(clk), .rst_n(rst_n), .pls(rx_p), .level(rx_level), .link_ok(link_ok)
  );

endmodule

// File: tb/sim_isolink_codec.sv
module sim_isolink_codec;
  localparam int CLK_PERIOD = 10;
  localparam int I_CYC = 8;
  localparam int R_CYC = 6;
  localparam int T_CYC = 20;
  localparam bit DEF   = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic cut = 1'b0;
  logic inj = 1'b0;
  logic tx_set, tx_clr, rx_set, rx_clr, rx_level, link_ok;

  assign rx_set = !cut && (tx_set || inj);
  assign rx_clr = !cut && (tx_clr || inj);

  isolink_codec #(.IDLE_CYC(I_CYC), .REFRESH_CYC(R_CYC), .TIMEOUT_CYC(T_CYC),
                  .DEFAULT_LVL(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_set(tx_set), .tx_clr(tx_clr),
    .rx_set(rx_set), .rx_clr(rx_clr), .rx_level(rx_level), .link_ok(link_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct { int c; logic lvl; } pexp_t;
  pexp_t q[$];

  int   total = 0;
  int   bad = 0;
  bit   mon_on = 1'b0;
  logic mq = DEF;
  logic mv = 1'b0;
  int   quiet = 0;
  logic lvl = 1'b0;
  int   nxt = I_CYC;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one cycle forward, pushing any refresh due in the next cycle
  task automatic tick();
    if (cyc + 1 == nxt) begin
      q.push_back('{cyc + 1, lvl});
      nxt += R_CYC;
    end
    @(posedge clk); #1;
  endtask

  task automatic hold(input int n);
    repeat (n) tick();
  endtask

  task automatic drive(input logic v);
    if (v != lvl) begin
      din = v;
      lvl = v;
      q.push_back('{cyc + 1, v});
      nxt = cyc + 1 + I_CYC;
      @(posedge clk); #1;
    end else begin
      tick();
    end
  endtask

  // monitor: pulse scoreboard and receive-side model
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_set && tx_clr)
        chk(1'b0, "R6 both pulse pins high", 1, 0);
      if (tx_set || tx_clr) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4 unexpected pulse", int'(tx_set), -1);
        end else begin
          pexp_t e;
          e = q.pop_front();
          chk(e.c == cyc, "R2 R3 R4 R5 pulse cycle", cyc, e.c);
          chk(tx_set == e.lvl, "R2 R3 R4 pulse kind", int'(tx_set), int'(e.lvl));
        end
      end
      chk(rx_level == mq, "R7 R10 rx_level model", int'(rx_level), int'(mq));
      chk(link_ok == mv, "R9 R10 link_ok model", int'(link_ok), int'(mv));
      if (rx_set ^ rx_clr) begin
        mq = rx_set; mv = 1'b1; quiet = 0;
      end else if (mv) begin
        quiet++;
        if (quiet == T_CYC) begin
          mq = DEF; mv = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic d0;
    repeat (3) begin @(posedge clk); #1; end
    chk(rx_level == DEF, "R1 reset level", int'(rx_level), int'(DEF));
    chk(link_ok == 1'b0, "R1 reset link", int'(link_ok), 0);
    chk(!tx_set && !tx_clr, "R1 reset pulses", int'({tx_set, tx_clr}), 0);
    mon_on = 1'b1;
    rst_n = 1'b1;

    // idle refresh of level 0: pulses at I, I+R, I+2R
    hold(I_CYC + 2 * R_CYC + 1);
    chk(link_ok == 1'b1, "R9 link after first pulse", int'(link_ok), 1);
    chk(rx_level == 1'b0, "R4 refresh carries level 0", int'(rx_level), 0);

    // rising edge, short quiet, falling edge restarts idle window
    drive(1'b1);
    hold(4);
    chk(rx_level == 1'b1, "R2 level after set", int'(rx_level), 1);
    drive(1'b0);
    hold(I_CYC + R_CYC + 2);

    // back-to-back opposite edges
    drive(1'b1);
    drive(1'b0);
    drive(1'b1);
    hold(3);
    chk(rx_level == 1'b1, "R5 level after quick edges", int'(rx_level), 1);
    drive(1'b0);
    hold(I_CYC);

    // fault: both receive lines high on the cycle an edge pulse arrives
    drive(1'b1);
    inj = 1'b1;
    d0 = rx_level;
    tick();
    inj = 1'b0;
    chk(rx_level == d0 && d0 == 1'b0, "R8 both lines hold level", int'(rx_level), 0);
    chk(link_ok == 1'b1, "R8 both lines keep link", int'(link_ok), 1);
    hold(I_CYC + 2);
    chk(rx_level == 1'b1, "R4 refresh repairs level", int'(rx_level), 1);

    // long steady input: link must stay up
    hold(8 * T_CYC);
    chk(link_ok == 1'b1, "R11 steady input keeps link", int'(link_ok), 1);

    // channel gated off at level 0: watchdog falls back to default
    drive(1'b0);
    hold(3);
    cut = 1'b1;
    hold(T_CYC + 4);
    chk(link_ok == 1'b0, "R10 link drops on silence", int'(link_ok), 0);
    chk(rx_level == DEF, "R10 default level on silence", int'(rx_level), int'(DEF));
    cut = 1'b0;
    hold(R_CYC + 2);
    chk(link_ok == 1'b1, "R9 link returns", int'(link_ok), 1);
    chk(rx_level == 1'b0, "R9 level returns", int'(rx_level), 0);

    hold(2);
    chk(q.size() == 0, "R4 expected pulses left", q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule